// File: doc/BRIEF.md
# GPIO Port Controller with Interrupt Detection

This block controls a 32-pin general-purpose I/O port through a small word-addressed register bus. Each pin has seven configuration bits: output data, interrupt mask, pull-resistor disable, function enable, function select, direction and trigger type. Software does not write these bits directly. Every configuration register has a set alias and a clear alias, and a 1 in the written word sets or clears the matching bit. Bits written as 0 are left as they were. Because of this, one driver can change some pins without a read-modify-write that might overwrite changes made by another driver.

For each pin the block produces an output enable, an output value and a pull enable. A pin works as a plain GPIO, as an interrupt source, or as one of two alternate functions whose output controls come in from outside the block. Pin inputs pass through a two-flop synchronizer. The synchronized levels can be read back. For pins in interrupt mode they are also checked for a level or an edge. The direction bit chooses the polarity. A detected condition sets a flag bit whether or not the pin is masked. Software can only clear flags. A single interrupt line is asserted while any unmasked flag is set.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, the mask register reads 0xFFFFFFFF and the data, pull, function, select, direction, trigger and flag registers read 0. All pull enables are high, all output enables are low and `irq` is low.
- R2: A write to a set alias (word address = group*4+1) sets every register bit whose written bit is 1 and leaves the other bits unchanged. The group numbers are data=1, mask=2, pull=3, function=4, select=5, direction=6 and trigger=7.
- R3: A write to a clear alias (word address = group*4+2) clears every register bit whose written bit is 1 and leaves the other bits unchanged.
- R4: A read of the base (group*4), the set alias or the clear alias of a configuration register returns the register's value. Writes to a base address and writes to the pin-state word (address 0) change no register.
- R5: Reading address 0 returns the pin levels after two clock edges of synchronization. A value read one edge after a pin change still shows the old level.
- R6: When function=0 and select=0, the pin's output enable equals its direction bit and its output value equals its data bit.
- R7: When function=1, the output enable and output value come from alternate source 0 if select=0 and from alternate source 1 if select=1.
- R8: Each pull enable output is the inverse of the pin's pull bit, so a 1 in the pull bit disables the pull resistor.
- R9: For a pin in interrupt mode (function=0, select=1) with trigger=0, the flag is set while the synchronized level equals the direction bit. A clear arriving while the level is still present leaves the flag set.
- R10: For a pin in interrupt mode with trigger=1, the flag is set by a rising edge when direction=1 and by a falling edge when direction=0. The opposite edge does not set the flag.
- R11: The flag register is at word 32 and its clear alias is at word 34. Writing 1 to the clear alias clears that flag. A write to word 32 or word 33 cannot set any flag.
- R12: Flags are set even when the pin is masked. `irq` is high exactly when some flag is set and its mask bit is 0.
- R13: A pin that is not in interrupt mode (plain GPIO or either alternate function) never sets its flag, whatever its input level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_waddr | input | 6 | Word address (group*4 + alias) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| pad_in | input | 32 | Raw pin levels |
| pad_oe | output | 32 | Per-pin output enable |
| pad_out | output | 32 | Per-pin output value |
| pad_pull_en | output | 32 | Per-pin pull resistor enable |
| alt0_oe | input | 32 | Alternate source 0 output enable |
| alt0_out | input | 32 | Alternate source 0 output value |
| alt1_oe | input | 32 | Alternate source 1 output enable |
| alt1_out | input | 32 | Alternate source 1 output value |
| irq | output | 1 | Combined interrupt request |

## Verification
Interrupt detection is run with four trigger patterns: a held low level, a rising edge, a falling edge, and edges of the wrong polarity. The held level shows whether a clear loses to a condition that is still present. The wrong-polarity edges show whether the direction bit really selects polarity or whether any edge is accepted. The set and clear aliases are given overlapping and disjoint bit patterns, which shows whether the untouched bits are kept. The drive paths are checked with distinct data and alternate-source patterns, so any crossed mux leg is visible.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
package gpio_port_pkg;
  // Configuration registers in address group order (group = index + 1)
  typedef enum int {
    CFG_DATA = 0,
    CFG_MASK = 1,
    CFG_PULL = 2,
    CFG_FUNC = 3,
    CFG_SEL  = 4,
    CFG_DIR  = 5,
    CFG_TRIG = 6
  } cfg_idx_e;

  localparam int NUM_CFG   = 7;
  localparam int GRP_PIN   = 0;
  localparam int GRP_FLAG  = NUM_CFG + 1;

  // Alias selector in the two low word-address bits
  localparam logic [1:0] SUB_BASE = 2'd0;
  localparam logic [1:0] SUB_SET  = 2'd1;
  localparam logic [1:0] SUB_CLR  = 2'd2;
  localparam logic [1:0] SUB_RSV  = 2'd3;
endpackage

// File: rtl/gpio_setclr_reg.sv
`timescale 1ns/1ps
module gpio_setclr_reg #(
  parameter int W = 32,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] wbits,
  output logic [W-1:0] q
);
  logic [W-1:0] set_m, clr_m;

  always_comb begin
    set_m = set_en ? wbits : '0;
    clr_m = clr_en ? wbits : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST;
    else        q <= (q | set_m) & ~clr_m;
  end
endmodule

// File: rtl/gpio_pin_sync.sv
`timescale 1ns/1ps
module gpio_pin_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] sync_q,
  output logic [W-1:0] prev_q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      prev_q <= '0;
    end else begin
      stg[0] <= pad_in;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      prev_q <= stg[STAGES-1];
    end
  end

  assign sync_q = stg[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
module gpio_irq_detect #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sync_q,
  input  logic [W-1:0] prev_q,
  input  logic [W-1:0] func_q,
  input  logic [W-1:0] sel_q,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] trig_q,
  input  logic [W-1:0] mask_q,
  input  logic         clr_en,
  input  logic [W-1:0] wbits,
  output logic [W-1:0] flag_q,
  output logic         irq
);
  logic [W-1:0] hit;

  for (genvar p = 0; p < W; p++) begin : g_pin
    logic armed, rise, fall, lvl_ok, edge_ok;
    always_comb begin
      armed   = ~func_q[p] & sel_q[p];
      rise    = sync_q[p] & ~prev_q[p];
      fall    = ~sync_q[p] & prev_q[p];
      lvl_ok  = ~(sync_q[p] ^ dir_q[p]);
      edge_ok = dir_q[p] ? rise : fall;
      hit[p]  = armed & (trig_q[p] ? edge_ok : lvl_ok);
    end
  end

  // A new condition wins over a simultaneous clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~(clr_en ? wbits : '0)) | hit;
  end

  assign irq = |(flag_q & ~mask_q);
endmodule

// File: rtl/gpio_pad_route.sv
`timescale 1ns/1ps
module gpio_pad_route #(
  parameter int W = 32
) (
  input  logic [W-1:0] data_q,
  input  logic [W-1:0] pull_q,
  input  logic [W-1:0] func_q,
  input  logic [W-1:0] sel_q,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] alt0_oe,
  input  logic [W-1:0] alt0_out,
  input  logic [W-1:0] alt1_oe,
  input  logic [W-1:0] alt1_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_pull_en
);
  for (genvar p = 0; p < W; p++) begin : g_pin
    always_comb begin
      if (func_q[p]) begin
        pad_oe[p]  = sel_q[p] ? alt1_oe[p]  : alt0_oe[p];
        pad_out[p] = sel_q[p] ? alt1_out[p] : alt0_out[p];
      end else begin
        pad_oe[p]  = ~sel_q[p] & dir_q[p];
        pad_out[p] = data_q[p];
      end
      pad_pull_en[p] = ~pull_q[p];
    end
  end
endmodule

// File: rtl/gpio_irq_port.sv
`timescale 1ns/1ps
module gpio_irq_port
  import gpio_port_pkg::*;
#(
  parameter int W      = 32,
  parameter int SYNC_N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_sel,
  input  logic         bus_wr,
  input  logic [5:0]   bus_waddr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_pull_en,
  input  logic [W-1:0] alt0_oe,
  input  logic [W-1:0] alt0_out,
  input  logic [W-1:0] alt1_oe,
  input  logic [W-1:0] alt1_out,
  output logic         irq
);
  logic [3:0]   grp;
  logic [1:0]   sub;
  logic         wr_hit;
  logic [W-1:0] cfg_q [NUM_CFG];
  logic [W-1:0] data_q, mask_q, pull_q, func_q, sel_q, dir_q, trig_q;
  logic [W-1:0] sync_q, prev_q, flag_q;
  logic         flag_clr;

  assign grp    = bus_waddr[5:2];
  assign sub    = bus_waddr[1:0];
  assign wr_hit = bus_sel & bus_wr;

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    localparam logic [W-1:0] RST_V = (g == int'(CFG_MASK)) ? {W{1'b1}} : '0;
    logic s_en, c_en;
    assign s_en = wr_hit && (grp == 4'(g + 1)) && (sub == SUB_SET);
    assign c_en = wr_hit && (grp == 4'(g + 1)) && (sub == SUB_CLR);
    gpio_setclr_reg #(.W(W), .RST(RST_V)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .set_en(s_en),
      .clr_en(c_en),
      .wbits (bus_wdata),
      .q     (cfg_q[g])
    );
  end

  assign data_q = cfg_q[CFG_DATA];
  assign mask_q = cfg_q[CFG_MASK];
  assign pull_q = cfg_q[CFG_PULL];
  assign func_q = cfg_q[CFG_FUNC];
  assign sel_q  = cfg_q[CFG_SEL];
  assign dir_q  = cfg_q[CFG_DIR];
  assign trig_q = cfg_q[CFG_TRIG];

  assign flag_clr = wr_hit && (grp == 4'(GRP_FLAG)) && (sub == SUB_CLR);

  gpio_pin_sync #(.W(W), .STAGES(SYNC_N)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pad_in(pad_in),
    .sync_q(sync_q),
    .prev_q(prev_q)
  );

  gpio_irq_detect #(.W(W)) u_det (
    .clk   (clk),
    .rst_n (rst_n),
    .sync_q(sync_q),
    .prev_q(prev_q),
    .func_q(func_q),
    .sel_q (sel_q),
    .dir_q (dir_q),
    .trig_q(trig_q),
    .mask_q(mask_q),
    .clr_en(flag_clr),
    .wbits (bus_wdata),
    .flag_q(flag_q),
    .irq   (irq)
  );

  gpio_pad_route #(.W(W)) u_route (
    .data_q     (data_q),
    .pull_q     (pull_q),
    .func_q     (func_q),
    .sel_q      (sel_q),
    .dir_q      (dir_q),
    .alt0_oe    (alt0_oe),
    .alt0_out   (alt0_out),
    .alt1_oe    (alt1_oe),
    .alt1_out   (alt1_out),
    .pad_oe     (pad_oe),
    .pad_out    (pad_out),
    .pad_pull_en(pad_pull_en)
  );

  // Read path: every alias of a register returns its value
  always_comb begin
    bus_rdata = '0;
    if (grp == 4'(GRP_PIN) && sub == SUB_BASE) bus_rdata = sync_q;
    if (grp == 4'(GRP_FLAG) && sub != SUB_RSV) bus_rdata = flag_q;
    for (int g = 0; g < NUM_CFG; g++)
      if (grp == 4'(g + 1) && sub != SUB_RSV) bus_rdata = cfg_q[g];
  end
endmodule

// File: rtl/gpio_irq_port_chk.sv
`timescale 1ns/1ps
module gpio_irq_port_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_sel,
  input logic         bus_wr,
  input logic [5:0]   bus_waddr,
  input logic [W-1:0] bus_wdata,
  input logic [W-1:0] pad_oe,
  input logic [W-1:0] alt0_oe,
  input logic         irq,
  input logic [W-1:0] data_q,
  input logic [W-1:0] mask_q,
  input logic [W-1:0] func_q,
  input logic [W-1:0] sel_q,
  input logic [W-1:0] dir_q,
  input logic [W-1:0] flag_q
);
  p_set_alias_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_waddr == 6'd5)
      |=> ((data_q & $past(bus_wdata)) == $past(bus_wdata)));

  p_clr_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_waddr == 6'd6)
      |=> ((data_q & $past(bus_wdata)) == '0));

  p_pin_write_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_waddr == 6'd0)
      |=> ($stable(data_q) && $stable(mask_q)));

  p_gpio_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (((~func_q & ~sel_q) & (pad_oe ^ dir_q)) == '0));

  p_alt0_route_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (((func_q & ~sel_q) & (pad_oe ^ alt0_oe)) == '0));

  p_flag_only_armed_r13: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(sel_q & ~func_q)) == '0));

  p_masked_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == {W{1'b1}}) |-> !irq);
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_sel  (bus_sel),
  .bus_wr   (bus_wr),
  .bus_waddr(bus_waddr),
  .bus_wdata(bus_wdata),
  .pad_oe   (pad_oe),
  .alt0_oe  (alt0_oe),
  .irq      (irq),
  .data_q   (data_q),
  .mask_q   (mask_q),
  .func_q   (func_q),
  .sel_q    (sel_q),
  .dir_q    (dir_q),
  .flag_q   (flag_q)
);

// File: tb/sim_gpio_irq_port.sv
`timescale 1ns/1ps
module sim_gpio_irq_port;
  // Word addresses: group*4 + alias (0 base, 1 set, 2 clear)
  localparam logic [5:0] A_PIN  = 6'd0;
  localparam logic [5:0] A_DATA = 6'd4;
  localparam logic [5:0] A_MASK = 6'd8;
  localparam logic [5:0] A_PULL = 6'd12;
  localparam logic [5:0] A_FUNC = 6'd16;
  localparam logic [5:0] A_SEL  = 6'd20;
  localparam logic [5:0] A_DIR  = 6'd24;
  localparam logic [5:0] A_TRIG = 6'd28;
  localparam logic [5:0] A_FLAG = 6'd32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [5:0]  bus_waddr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [31:0] pad_in = '0, pad_oe, pad_out, pad_pull_en;
  logic [31:0] alt0_oe = '0, alt0_out = '0, alt1_oe = '0, alt1_out = '0;
  logic        irq;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_irq_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_waddr(bus_waddr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
    .pad_pull_en(pad_pull_en), .alt0_oe(alt0_oe), .alt0_out(alt0_out),
    .alt1_oe(alt1_oe), .alt1_out(alt1_out), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_waddr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_waddr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_DATA, v); check("R1 data", v, 32'h0);
    rd(A_MASK, v); check("R1 mask", v, 32'hFFFF_FFFF);
    rd(A_PULL, v); check("R1 pull", v, 32'h0);
    rd(A_FUNC, v); check("R1 func", v, 32'h0);
    rd(A_SEL,  v); check("R1 sel",  v, 32'h0);
    rd(A_DIR,  v); check("R1 dir",  v, 32'h0);
    rd(A_TRIG, v); check("R1 trig", v, 32'h0);
    rd(A_FLAG, v); check("R1 flag", v, 32'h0);
    check("R1 pull_en", pad_pull_en, 32'hFFFF_FFFF);
    check("R1 oe", pad_oe, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_setclr();
    logic [31:0] v;
    wr(A_DATA + 1, 32'hF0F0_00FF);
    wr(A_DATA + 1, 32'h0000_0F00);
    rd(A_DATA, v); check("R2 set keeps other bits", v, 32'hF0F0_0FFF);
    wr(A_DATA + 2, 32'h0F00_00F0);
    rd(A_DATA, v); check("R3 clear keeps other bits", v, 32'hF0F0_0F0F);
    rd(A_DATA + 1, v); check("R4 read set alias", v, 32'hF0F0_0F0F);
    rd(A_DATA + 2, v); check("R4 read clear alias", v, 32'hF0F0_0F0F);
    wr(A_DATA, 32'h0);
    rd(A_DATA, v); check("R4 base write ignored", v, 32'hF0F0_0F0F);
    wr(A_PIN, 32'hFFFF_FFFF);
    rd(A_DATA, v); check("R4 pin write ignored data", v, 32'hF0F0_0F0F);
    rd(A_MASK, v); check("R4 pin write ignored mask", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_pinstate();
    logic [31:0] v;
    @(negedge clk); pad_in = 32'hA5C3_0F01;
    rd(A_PIN, v); check("R5 one edge old", v, 32'h0);
    rd(A_PIN, v); check("R5 two edges new", v, 32'hA5C3_0F01);
    pad_in = '0; settle();
  endtask

  task automatic t_gpio_drive();
    wr(A_DIR + 1, 32'h0000_FFFF);
    #1;
    check("R6 oe", pad_oe, 32'h0000_FFFF);
    check("R6 out", pad_out, 32'hF0F0_0F0F);
    wr(A_PULL + 1, 32'h8000_0001);
    #1 check("R8 pull_en", pad_pull_en, 32'h7FFF_FFFE);
    wr(A_PULL + 2, 32'hFFFF_FFFF);
    wr(A_DIR + 2, 32'hFFFF_FFFF);
  endtask

  task automatic t_alt();
    alt0_oe = 32'h0000_0300; alt0_out = 32'h0000_0100;
    alt1_oe = 32'h0000_0000; alt1_out = 32'h0000_0200;
    wr(A_FUNC + 1, 32'h0000_0300);
    #1;
    check("R7 alt0 oe", pad_oe & 32'h300, 32'h300);
    check("R7 alt0 out", pad_out & 32'h300, 32'h100);
    wr(A_SEL + 1, 32'h0000_0300);
    #1;
    check("R7 alt1 oe", pad_oe & 32'h300, 32'h0);
    check("R7 alt1 out", pad_out & 32'h300, 32'h200);
    wr(A_SEL + 2, 32'h0000_0300);
    wr(A_FUNC + 2, 32'h0000_0300);
  endtask

  task automatic t_level();
    logic [31:0] v;
    wr(A_SEL + 1, 32'h8);      // pin 3: level, low active
    settle();
    rd(A_FLAG, v); check("R9 low level flags", v, 32'h8);
    wr(A_FLAG + 2, 32'h8);
    rd(A_FLAG, v); check("R9 persisting level re-sets", v, 32'h8);
    @(negedge clk); pad_in[3] = 1'b1;
    settle();
    wr(A_FLAG + 2, 32'h8);
    rd(A_FLAG, v); check("R9 cleared once level gone", v, 32'h0);
    wr(A_SEL + 2, 32'h8);
    @(negedge clk); pad_in[3] = 1'b0;
    settle();
  endtask

  task automatic t_edge();
    logic [31:0] v;
    wr(A_TRIG + 1, 32'h20);
    wr(A_DIR + 1, 32'h20);
    wr(A_SEL + 1, 32'h20);
    wr(A_FLAG + 2, 32'hFFFF_FFFF);
    @(negedge clk); pad_in[5] = 1'b1; settle();
    rd(A_FLAG, v); check("R10 rising with dir 1", v, 32'h20);
    wr(A_FLAG + 2, 32'h20);
    rd(A_FLAG, v); check("R11 clear alias clears edge flag", v, 32'h0);
    @(negedge clk); pad_in[5] = 1'b0; settle();
    rd(A_FLAG, v); check("R10 falling ignored with dir 1", v, 32'h0);
    wr(A_DIR + 2, 32'h20);
    @(negedge clk); pad_in[5] = 1'b1; settle();
    rd(A_FLAG, v); check("R10 rising ignored with dir 0", v, 32'h0);
    @(negedge clk); pad_in[5] = 1'b0; settle();
    rd(A_FLAG, v); check("R10 falling with dir 0", v, 32'h20);
    wr(A_SEL + 2, 32'h20);
    wr(A_TRIG + 2, 32'h20);
    wr(A_FLAG + 2, 32'h20);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(A_SEL + 1, 32'h8);
    settle();
    rd(A_FLAG, v); check("R12 flag set while masked", v, 32'h8);
    check("R12 irq low while masked", {31'b0, irq}, 32'h0);
    wr(A_MASK + 2, 32'h10);
    #1 check("R12 other pin unmasked no irq", {31'b0, irq}, 32'h0);
    wr(A_MASK + 2, 32'h8);
    #1 check("R12 unmasked irq", {31'b0, irq}, 32'h1);
    wr(A_MASK + 1, 32'h18);
    #1 check("R12 masked again", {31'b0, irq}, 32'h0);
    wr(A_SEL + 2, 32'h8);
    wr(A_FLAG + 2, 32'h8);
  endtask

  task automatic t_noint();
    logic [31:0] v;
    wr(A_FLAG + 2, 32'hFFFF_FFFF);
    settle();
    rd(A_FLAG, v); check("R13 gpio low pins no flag", v, 32'h0);
    wr(A_FUNC + 1, 32'h80);
    wr(A_SEL + 1, 32'h80);
    settle();
    rd(A_FLAG, v); check("R13 alt1 pin no flag", v, 32'h0);
    wr(A_SEL + 2, 32'h80);
    wr(A_FUNC + 2, 32'h80);
  endtask

  task automatic t_flag_sw();
    logic [31:0] v;
    wr(A_FLAG, 32'hFFFF_FFFF);
    wr(A_FLAG + 1, 32'hFFFF_FFFF);
    rd(A_FLAG, v); check("R11 software cannot set flags", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_setclr();
    t_pinstate();
    t_gpio_drive();
    t_alt();
    t_level();
    t_edge();
    t_mask();
    t_noint();
    t_flag_sw();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule